// File: doc/BRIEF.md
# Serial Audio Input Word Capture

This block takes a three-wire serial audio stream (bit clock, word select, data) that runs on its own timing and turns it into parallel left and right sample words in the system clock domain. All three serial lines pass through a synchronizer and are sampled by the system clock. A rising edge of the synchronized bit clock marks one data bit. Each change of channel closes the word that was being collected.

Three framings are supported. Left-Justified and I2S inputs are always taken as full 24-bit words. Right-Justified input is cut to a resolution chosen by the user: 16, 20 or 24 bits. Nothing is dithered. When a slot carries fewer bit clocks than the word needs, the bits that never arrived become zeros. Every result is MSB-aligned in a 24-bit word. A pair is presented together with a one-cycle valid strobe, which a downstream rate converter reads.

Top module: `sai_word_capture`

## Requirements
- R1: While reset is asserted, and until the first complete frame has been captured after reset, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: In Left-Justified format (`fmt_i` = 0 or 3), `ws_i` high marks the left channel. The MSB is the bit sampled at the first rising bit clock after the word-select change. The first 24 bits of the slot are kept, and any later bits in the slot are ignored.
- R3: In I2S format (`fmt_i` = 1), `ws_i` low marks the left channel. The MSB arrives one bit clock after the word-select change, and the first 24 bits of the slot are kept.
- R4: In Right-Justified format (`fmt_i` = 2), `ws_i` high marks the left channel, and the word is made of the last N bits of the slot. N is 16 for `res_i` = 0, 20 for `res_i` = 1, and 24 for `res_i` = 2 or 3.
- R5: In Left-Justified or I2S format, a slot with fewer than 24 bit clocks yields its received bits in the top positions, and all missing low bits are zero.
- R6: In Right-Justified format, a slot with fewer than N bit clocks yields the received bits as the low part of the N-bit word, and the missing high bits are zero.
- R7: In Right-Justified format with N below 24, the word is placed MSB-aligned and the lowest 24-N bits of the output are zero. No dither or rounding is applied.
- R8: `valid_o` is a one-cycle pulse, given once per stereo frame when the right slot ends, which is when the next left slot starts. `left_o` and `right_o` change only in that cycle and hold their values otherwise.
- R9: A partial slot that is in progress when reset is released is discarded. No pair is output until a complete left slot and a complete right slot have been captured, both bounded by channel changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ws_i | input | 1 | Word select (frame clock) |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 0/3 Left-Justified, 1 I2S, 2 Right-Justified |
| res_i | input | 2 | Right-Justified resolution: 0 = 16, 1 = 20, 2/3 = 24 bits |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe: a new pair is on the outputs |

## Verification
A bit counter or shift register that is off by one shows up in the very next pair as a word shifted by one position. It can also show as a pad bit of value one leaking into the low end of the word, or as a top bit being lost. Pad bits are set to one on purpose so that this error is visible. A wrong channel decode or wrong slot-boundary tracking swaps or misses pairs within one frame. It can also produce a spurious strobe from the preamble slot after reset, and the scoreboard catches this as an unexpected or missing item. A wrong resolution mask leaves nonzero low bits, which both the bench and the checker flag on the first strobe.

// File: rtl/sai_pkg.sv
package sai_pkg;
  typedef enum logic [1:0] {
    FMT_LJ   = 2'd0,
    FMT_I2S  = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_LJ_B = 2'd3
  } sai_fmt_e;
endpackage

// File: rtl/sai_sync.sv
module sai_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sai_bit_strobe.sv
module sai_bit_strobe
  import sai_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_s_i,
  input  logic       ws_s_i,
  input  logic       sd_s_i,
  input  logic [1:0] fmt_i,
  output logic       stb_o,
  output logic       bit_o,
  output logic       left_o
);
  logic sck_q, ws_q;
  logic rise;

  assign rise = sck_s_i & ~sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      ws_q   <= 1'b1;
      stb_o  <= 1'b0;
      bit_o  <= 1'b0;
      left_o <= 1'b0;
    end else begin
      sck_q <= sck_s_i;
      stb_o <= rise;
      if (rise) begin
        ws_q  <= ws_s_i;
        bit_o <= sd_s_i;
        // I2S: the bit at a ws change still belongs to the previous slot
        left_o <= (sai_fmt_e'(fmt_i) == FMT_I2S) ? ~ws_q : ws_s_i;
      end
    end
  end
endmodule

// File: rtl/sai_slot_shift.sv
module sai_slot_shift
  import sai_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              bit_i,
  input  logic              left_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        res_i,
  output logic              done_o,
  output logic              done_left_o,
  output logic [WORD_W-1:0] done_word_o
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sr_q;
  logic [CW-1:0]     cnt_q;
  logic              cur_left_q, started_q, armed_q;
  logic              is_rj;
  logic [CW-1:0]     nres;
  logic [WORD_W-1:0] mask, fmt_word;

  assign is_rj = (sai_fmt_e'(fmt_i) == FMT_RJ);

  always_comb begin
    case (res_i)
      2'd0:    nres = CW'(WORD_W - 8);
      2'd1:    nres = CW'(WORD_W - 4);
      default: nres = CW'(WORD_W);
    endcase
    mask = {WORD_W{1'b1}} >> (WORD_W - int'(nres));
    if (is_rj) fmt_word = (sr_q & mask) << (WORD_W - int'(nres));
    else       fmt_word = sr_q << (WORD_W - int'(cnt_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q        <= '0;
      cnt_q       <= '0;
      cur_left_q  <= 1'b0;
      started_q   <= 1'b0;
      armed_q     <= 1'b0;
      done_o      <= 1'b0;
      done_left_o <= 1'b0;
      done_word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (stb_i) begin
        started_q  <= 1'b1;
        cur_left_q <= left_i;
        if (started_q && (left_i != cur_left_q)) begin
          done_o      <= armed_q;  // first slot after reset is partial
          done_left_o <= cur_left_q;
          done_word_o <= fmt_word;
          armed_q     <= 1'b1;
          sr_q        <= {{(WORD_W-1){1'b0}}, bit_i};
          cnt_q       <= CW'(1);
        end else begin
          if (is_rj || (cnt_q < CW'(WORD_W))) sr_q <= {sr_q[WORD_W-2:0], bit_i};
          if (cnt_q < CW'(WORD_W)) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sai_word_capture.sv
module sai_word_capture #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        res_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic [2:0]        raw, syn;
  logic              stb, bit_v, bit_left;
  logic              done, done_left;
  logic [WORD_W-1:0] done_word, lbuf_q;
  logic              lhave_q;

  assign raw = {sck_i, ws_i, sd_i};

  sai_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  sai_bit_strobe u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_s_i(syn[2]),
    .ws_s_i (syn[1]),
    .sd_s_i (syn[0]),
    .fmt_i  (fmt_i),
    .stb_o  (stb),
    .bit_o  (bit_v),
    .left_o (bit_left)
  );

  sai_slot_shift #(.WORD_W(WORD_W)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (stb),
    .bit_i      (bit_v),
    .left_i     (bit_left),
    .fmt_i      (fmt_i),
    .res_i      (res_i),
    .done_o     (done),
    .done_left_o(done_left),
    .done_word_o(done_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lbuf_q  <= '0;
      lhave_q <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done) begin
        if (done_left) begin
          lbuf_q  <= done_word;
          lhave_q <= 1'b1;
        end else if (lhave_q) begin
          left_o  <= lbuf_q;
          right_o <= done_word;
          valid_o <= 1'b1;
          lhave_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sai_word_capture_chk.sv
module sai_word_capture_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        fmt_i,
  input logic [1:0]        res_i,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              valid_o
);
  AST_QUIET_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!valid_o && left_o == '0 && right_o == '0)); // R1

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8

  AST_HOLD_WORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R8

  AST_RJ16_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fmt_i == 2'd2 && res_i == 2'd0) |-> (left_o[7:0] == '0 && right_o[7:0] == '0)); // R7

  AST_RJ20_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fmt_i == 2'd2 && res_i == 2'd1) |-> (left_o[3:0] == '0 && right_o[3:0] == '0)); // R7
endmodule

bind sai_word_capture sai_word_capture_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fmt_i  (fmt_i),
  .res_i  (res_i),
  .left_o (left_o),
  .right_o(right_o),
  .valid_o(valid_o)
);

// File: tb/sai_word_capture_test.sv
module sai_word_capture_test;
  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [1:0]  fmt = 2'd0, res = 2'd0;
  logic [23:0] left_o, right_o;
  logic        valid_o;
  int          checks = 0, fails = 0;
  item_t       exp_q[$];

  always #5 clk = ~clk;

  sai_word_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .fmt_i(fmt), .res_i(res), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  function automatic logic [23:0] exp_word(logic [1:0] f, logic [1:0] rs, logic [23:0] w, int nb);
    int n, m;
    logic [23:0] msk;
    if (f == 2'd2) begin
      n = (rs == 2'd0) ? 16 : (rs == 2'd1) ? 20 : 24;
      m = (nb < n) ? nb : n;
      msk = 24'hFFFFFF >> (24 - m);
      return (w & msk) << (24 - n);
    end
    m = (nb < 24) ? nb : 24;
    return (w >> (24 - m)) << (24 - m);
  endfunction

  task automatic send_bit(logic w_s, logic d);
    @(negedge clk);
    sck = 1'b0; ws = w_s; sd = d;
    repeat (3) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_slot(logic is_left, logic [23:0] w, int nb);
    logic ch_ws;
    ch_ws = (fmt == 2'd1) ? ~is_left : is_left;
    for (int i = 0; i < nb; i++) begin
      int idx;
      logic b, wv;
      if (fmt == 2'd2) begin
        idx = nb - 1 - i;
        b = (idx < 24) ? w[idx] : 1'b1;
      end else begin
        b = (i < 24) ? w[23 - i] : 1'b1;
      end
      wv = (fmt == 2'd1 && i == nb - 1) ? ~ch_ws : ch_ws;
      send_bit(wv, b);
    end
  endtask

  task automatic check(string req, logic [23:0] act, logic [23:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic burst(logic [1:0] f, logic [1:0] rs, int nb, int seed, string req);
    @(negedge clk);
    rst_n = 1'b0; sck = 1'b0; fmt = f; res = rs;
    repeat (4) @(negedge clk);
    check("R1", {23'd0, valid_o}, 24'd0);
    check("R1", left_o | right_o, 24'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send_slot(1'b0, 24'hFFFFFF, 5); // partial preamble, R9
    for (int k = 0; k < 2; k++) begin
      logic [23:0] lw, rw;
      item_t it;
      lw = 24'h9A3C5F ^ (24'h1357B9 * (seed + k));
      rw = 24'hC6E1A7 ^ (24'h2468AD * (seed + k + 3));
      it.l = exp_word(f, rs, lw, nb);
      it.r = exp_word(f, rs, rw, nb);
      it.req = req;
      exp_q.push_back(it);
      send_slot(1'b1, lw, nb);
      send_slot(1'b0, rw, nb);
    end
    send_slot(1'b1, 24'h000000, 4);
    repeat (20) @(negedge clk);
    check("R8", 24'(exp_q.size()), 24'd0);
    exp_q.delete();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 actual=unexpected_valid expected=none");
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(it.req, left_o, it.l);
        check(it.req, right_o, it.r);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    burst(2'd0, 2'd0, 32, 1, "R2");  // LJ, trailing pad ignored
    burst(2'd3, 2'd1, 24, 2, "R2");  // LJ alias code
    burst(2'd0, 2'd0, 16, 3, "R5");  // LJ short slot
    burst(2'd1, 2'd0, 32, 4, "R3");  // I2S
    burst(2'd1, 2'd2, 24, 5, "R3");
    burst(2'd1, 2'd0, 20, 6, "R5");  // I2S short slot
    burst(2'd2, 2'd0, 32, 7, "R7");  // RJ 16
    burst(2'd2, 2'd1, 24, 8, "R7");  // RJ 20
    burst(2'd2, 2'd2, 32, 9, "R4");  // RJ 24
    burst(2'd2, 2'd3, 24, 10, "R4");
    burst(2'd2, 2'd2, 16, 11, "R6"); // RJ short slot
    burst(2'd2, 2'd1, 12, 12, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule